// File: doc/BRIEF.md
# Byte-Register Serial Management Slave

This block is the management-side endpoint of a two-wire serial management link (clock MDC, bidirectional data MDIO). It uses a modified management frame to reach a flat space of 256 byte-wide registers. The frame keeps the usual preamble, start pattern, turnaround and 16-bit data field. The opcode is always `00`. The transfer direction is carried in the top bit of the 5-bit device-address field, and that field's three low bits carry bits 7:5 of the register address.

The slave samples MDIO on every rising MDC edge and is clocked by MDC itself. It presents read data through a registered output and a separate output-enable, so the pad-level tri-state stays outside the block. Internally, a frame decoder drives one shared read/write port into a byte register file that is written for block-RAM inference. A shift stage serialises the fetched byte back onto the line. The register file is not cleared by reset. Its contents are reached only through frames.

Top module: `smi_mgmt_slave`

## Requirements
- R1: One rising MDC edge with `rst` high leaves `mdio_oe` low.
- R2: A frame is recognised only after at least 32 consecutive ones sampled on MDIO, followed by a 0 and then a 1. A preamble longer than 32 ones is accepted.
- R3: The register address is formed as {device field bits 2:0, register field bits 4:0}, both fields sent MSB first. Device field bit 3 has no effect.
- R4: Device field bit 4 set to 1 selects a read, and 0 selects a write. A write frame never raises `mdio_oe`.
- R5: On a read, `mdio_oe` stays low during the first turnaround bit period. During the second turnaround bit period, `mdio_oe` is high and `mdio_out` is 0.
- R6: The 16 read data bits follow MSB first. The upper eight are 0, and the lower eight are the addressed register byte.
- R7: `mdio_oe` is high for exactly 17 bit periods per read (turnaround plus data). It falls in the bit period after the last data bit.
- R8: A write stores data bits 7:0 into the addressed register. Data bits 15:8 are discarded.
- R9: A write takes effect only once the 16th data bit is sampled. A frame cut short by reset leaves the register unchanged.
- R10: A frame whose two opcode bits are not `00` neither drives MDIO nor writes a register. The next properly preambled frame is decoded normally.
- R11: A frame preceded by only 31 ones is ignored: no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_in | input | 1 | Sampled level of the MDIO line |
| mdio_out | output | 1 | Registered value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the MDIO tri-state buffer |

## Verification
The hardest state to reach from the pins is a write that has advanced into the data field but not finished. Only a reset arriving partway through the data bits exposes whether the register is updated early. The bench cuts a write off after ten data bits, applies reset, and reads the register back to confirm that its old byte survived. The short-preamble and bad-opcode cases are also hard to reach, because the decoder must resynchronise onto the following frame. The bench follows each such frame directly with a legal frame and a read-back.

// File: rtl/smi_pkg.sv
package smi_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_OPC,
    S_DEV,
    S_REG,
    S_TURN,
    S_DATA
  } smi_state_e;

endpackage

// File: rtl/smi_byte_ram.sv
module smi_byte_ram #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  // single port, registered read: maps onto one block RAM port
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/smi_frame_ctl.sv
module smi_frame_ctl
  import smi_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DEV_W   = 5,
  parameter int REG_W   = 5,
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 16,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_in,
  output logic              rd_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              ta_drive,
  output logic              tx_load
);

  localparam int HI_W  = ADDR_W - REG_W;
  localparam int CMAX  = (PRE_LEN > WORD_W) ? PRE_LEN : WORD_W;
  localparam int CNT_W = $clog2(CMAX + 1);

  smi_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              opc_hi;
  logic              is_rd;
  logic [DEV_W-1:0]  dev_sh;
  logic [REG_W-1:0]  reg_sh;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_sh;
  logic [ADDR_W-1:0] addr_now;

  assign addr_now = {dev_sh[HI_W-1:0], reg_sh[REG_W-2:0], mdio_in};

  wire last_reg  = (state == S_REG)  && (cnt == CNT_W'(REG_W - 1));
  wire last_data = (state == S_DATA) && (cnt == CNT_W'(WORD_W - 1));

  assign rd_en    = last_reg && is_rd;
  assign wr_en    = last_data && !is_rd;
  assign addr     = (state == S_REG) ? addr_now : addr_q;
  assign wdata    = {data_sh[BYTE_W-2:0], mdio_in};
  assign ta_drive = (state == S_TURN) && (cnt == '0) && is_rd;
  assign tx_load  = (state == S_TURN) && (cnt == CNT_W'(1)) && is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_HUNT;
      cnt     <= '0;
      opc_hi  <= 1'b0;
      is_rd   <= 1'b0;
      dev_sh  <= '0;
      reg_sh  <= '0;
      addr_q  <= '0;
      data_sh <= '0;
    end else begin
      case (state)
        S_HUNT: begin
          if (mdio_in) begin
            if (cnt != CNT_W'(PRE_LEN)) cnt <= cnt + 1'b1;
          end else if (cnt == CNT_W'(PRE_LEN)) begin
            state <= S_START;
            cnt   <= '0;
          end else begin
            cnt <= '0;
          end
        end
        S_START: begin
          cnt   <= '0;
          state <= mdio_in ? S_OPC : S_HUNT;
        end
        S_OPC: begin
          opc_hi <= mdio_in;
          if (cnt == '0) begin
            cnt <= CNT_W'(1);
          end else begin
            cnt   <= '0;
            state <= (!opc_hi && !mdio_in) ? S_DEV : S_HUNT;
          end
        end
        S_DEV: begin
          dev_sh <= {dev_sh[DEV_W-2:0], mdio_in};
          if (cnt == CNT_W'(DEV_W - 1)) begin
            is_rd <= dev_sh[DEV_W-2];
            cnt   <= '0;
            state <= S_REG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REG: begin
          reg_sh <= {reg_sh[REG_W-2:0], mdio_in};
          if (last_reg) begin
            addr_q <= addr_now;
            cnt    <= '0;
            state  <= S_TURN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TURN: begin
          if (cnt == CNT_W'(1)) begin
            cnt   <= '0;
            state <= S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          data_sh <= {data_sh[WORD_W-2:0], mdio_in};
          if (last_data) begin
            cnt   <= '0;
            state <= S_HUNT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt   <= '0;
          state <= S_HUNT;
        end
      endcase
    end
  end

endmodule

// File: rtl/smi_tx_shift.sv
module smi_tx_shift #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ta_drive,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              mdio_out,
  output logic              mdio_oe
);

  localparam int LEFT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] sh;
  logic [LEFT_W-1:0] left;

  assign word = {{(WORD_W - BYTE_W){1'b0}}, byte_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
      sh       <= '0;
      left     <= '0;
    end else if (load) begin
      mdio_oe  <= 1'b1;
      mdio_out <= word[WORD_W-1];
      sh       <= {word[WORD_W-2:0], 1'b0};
      left     <= LEFT_W'(WORD_W - 1);
    end else if (ta_drive) begin
      mdio_oe  <= 1'b1;
      mdio_out <= 1'b0;
      left     <= '0;
    end else if (left != '0) begin
      mdio_out <= sh[WORD_W-1];
      sh       <= {sh[WORD_W-2:0], 1'b0};
      left     <= left - 1'b1;
    end else begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end
  end

endmodule

// File: rtl/smi_mgmt_slave.sv
module smi_mgmt_slave #(
  parameter int PRE_LEN = 32,
  parameter int DEV_W   = 5,
  parameter int REG_W   = 5,
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 16,
  parameter int BYTE_W  = 8
) (
  input  logic mdc,
  input  logic rst,
  input  logic mdio_in,
  output logic mdio_out,
  output logic mdio_oe
);

  logic              rd_en;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wdata;
  logic [BYTE_W-1:0] rdata;
  logic              ta_drive;
  logic              tx_load;

  smi_frame_ctl #(
    .PRE_LEN(PRE_LEN), .DEV_W(DEV_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
  ) i_ctl (
    .clk(mdc), .rst(rst), .mdio_in(mdio_in),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ta_drive(ta_drive), .tx_load(tx_load)
  );

  smi_byte_ram #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_ram (
    .clk(mdc), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  smi_tx_shift #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_tx (
    .clk(mdc), .rst(rst), .ta_drive(ta_drive), .load(tx_load),
    .byte_in(rdata), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/smi_mgmt_slave_chk.sv
module smi_mgmt_slave_chk (
  input logic mdc,
  input logic rst,
  input logic mdio_oe,
  input logic mdio_out,
  input logic rd_en,
  input logic wr_en
);

  logic       rst_d = 1'b0;
  logic [4:0] run = '0;

  always_ff @(posedge mdc) begin
    rst_d <= rst;
    if (rst || !mdio_oe) run <= '0;
    else if (run != 5'd31) run <= run + 1'b1;
  end

  // R1
  always @(negedge mdc) begin
    if (rst_d) begin
      oe_reset_chk: assert (!mdio_oe) else $error("oe high after reset");
    end
  end

  // R4
  rd_fetch_chk: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> $past(rd_en, 2));

  // R4
  wr_quiet_chk: assert property (@(posedge mdc) disable iff (rst)
    wr_en |-> !mdio_oe);

  // R6
  upper_zero_chk: assert property (@(posedge mdc) disable iff (rst)
    (mdio_oe && run <= 5'd8) |-> !mdio_out);

  // R7
  drive_len_chk: assert property (@(posedge mdc) disable iff (rst)
    ($fell(mdio_oe) && !$past(rst)) |-> (run == 5'd17));

endmodule

bind smi_mgmt_slave smi_mgmt_slave_chk i_chk (
  .mdc(mdc), .rst(rst), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .rd_en(rd_en), .wr_en(wr_en)
);

// File: tb/test_smi_mgmt_slave.sv
module test_smi_mgmt_slave;

  localparam int CLK_P = 10;

  logic mdc = 1'b0;
  logic rst = 1'b1;
  logic mval = 1'b1;
  logic mdio_out, mdio_oe;
  wire  line;

  assign line = mdio_oe ? mdio_out : mval;

  smi_mgmt_slave i_smi_mgmt_slave (
    .mdc(mdc), .rst(rst), .mdio_in(line),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  always #(CLK_P / 2) mdc = ~mdc;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_mem [256];

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // one bit period: sample slave side, then set master level for next edge
  task automatic slot(input logic b, inout logic seen);
    @(negedge mdc);
    seen = seen | mdio_oe;
    mval = b;
  endtask

  task automatic xfer(input int pre, input logic [1:0] op, input logic rd,
                      input logic xb, input logic [7:0] a,
                      input logic [15:0] wd, input int nd,
                      output logic [15:0] rdat, output logic ta_ok,
                      output logic rel_ok, output logic seen);
    seen = 0; ta_ok = 1; rel_ok = 1; rdat = '0;
    for (int i = 0; i < pre; i++) slot(1'b1, seen);
    slot(1'b0, seen); slot(1'b1, seen);
    slot(op[1], seen); slot(op[0], seen);
    slot(rd, seen); slot(xb, seen);
    for (int i = 7; i >= 5; i--) slot(a[i], seen);
    for (int i = 4; i >= 0; i--) slot(a[i], seen);
    if (rd) begin
      @(negedge mdc); if (mdio_oe) ta_ok = 0; seen |= mdio_oe; mval = 1'b1;
      @(negedge mdc); if (!(mdio_oe && !mdio_out)) ta_ok = 0;
      seen |= mdio_oe; mval = 1'b1;
    end else begin
      slot(1'b1, seen); slot(1'b0, seen);
    end
    for (int i = 15; i > 15 - nd; i--) begin
      @(negedge mdc);
      seen |= mdio_oe;
      rdat[i] = line;
      mval = rd ? 1'b1 : wd[i];
    end
    if (rd) begin
      @(negedge mdc); rel_ok = !mdio_oe; mval = 1'b1;
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [15:0] wd,
                       input logic xb, input string req);
    logic [15:0] r; logic t, l, s;
    xfer(32, 2'b00, 1'b0, xb, a, wd, 16, r, t, l, s);
    chk(!s, {req, " R4 write frame drove mdio"}, {15'd0, s}, 16'd0);
    exp_mem[a] = wd[7:0];
  endtask

  task automatic do_rd(input logic [7:0] a, input logic xb, input string req);
    logic [15:0] r; logic t, l, s;
    xfer(32, 2'b00, 1'b1, xb, a, 16'h0, 16, r, t, l, s);
    chk(t, {req, " R5 turnaround"}, {15'd0, t}, 16'd1);
    chk(r == {8'h00, exp_mem[a]}, {req, " R6 read data"}, r, {8'h00, exp_mem[a]});
    chk(l, {req, " R7 release"}, {15'd0, l}, 16'd1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r; logic t, l, s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge mdc);
    chk(!mdio_oe, "R1 oe after reset", {15'd0, mdio_oe}, 16'd0);
    rst = 1'b0;

    // fill every register, random upper halves (R8)
    for (int a = 0; a < 256; a++)
      do_wr(8'(a), 16'($urandom), 1'($urandom), "R8 fill");

    // R3 boundaries and ignored device bit 3
    do_rd(8'h00, 1'b0, "R3 addr00");
    do_rd(8'hFF, 1'b1, "R3 addrFF");
    do_rd(8'hE0, 1'b0, "R3 addrE0");
    do_rd(8'h1F, 1'b1, "R3 addr1F");
    do_wr(8'h20, 16'h005A, 1'b1, "R3");
    do_rd(8'h20, 1'b0, "R3 bit3 ignored");

    // R8 upper data discarded
    do_wr(8'h43, 16'hFF3C, 1'b0, "R8");
    do_rd(8'h43, 1'b0, "R8 upper discarded");

    // R2 long preamble accepted
    xfer(40, 2'b00, 1'b0, 1'b0, 8'h44, 16'h00C3, 16, r, t, l, s);
    exp_mem[8'h44] = 8'hC3;
    do_rd(8'h44, 1'b0, "R2 long preamble");

    // R11 short preamble: previous frame was a write, so count starts at 0
    do_wr(8'h45, 16'h0011, 1'b0, "R11 setup");
    xfer(31, 2'b00, 1'b0, 1'b0, 8'h40, 16'h00A5, 16, r, t, l, s);
    do_rd(8'h40, 1'b0, "R11 short preamble ignored");

    // R10 bad opcodes
    xfer(32, 2'b01, 1'b0, 1'b0, 8'h41, 16'h0099, 16, r, t, l, s);
    chk(!s, "R10 op01 undriven", {15'd0, s}, 16'd0);
    xfer(32, 2'b10, 1'b1, 1'b0, 8'h41, 16'h0000, 16, r, t, l, s);
    chk(!s, "R10 op10 read undriven", {15'd0, s}, 16'd0);
    xfer(32, 2'b11, 1'b0, 1'b0, 8'h41, 16'h0077, 16, r, t, l, s);
    chk(!s, "R10 op11 undriven", {15'd0, s}, 16'd0);
    do_rd(8'h41, 1'b0, "R10 no write and resync");

    // R9 truncated write then reset
    xfer(32, 2'b00, 1'b0, 1'b0, 8'h42, 16'h00FF ^ {8'h00, exp_mem[8'h42]},
         10, r, t, l, s);
    @(negedge mdc); rst = 1'b1; mval = 1'b1;
    @(negedge mdc);
    @(negedge mdc);
    chk(!mdio_oe, "R1 oe after mid-frame reset", {15'd0, mdio_oe}, 16'd0);
    rst = 1'b0;
    do_rd(8'h42, 1'b0, "R9 truncated write");

    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(1, 0) == 1)
        do_wr(8'($urandom), 16'($urandom), 1'($urandom), "R4 rand");
      else
        do_rd(8'($urandom), 1'($urandom), "R4 rand");
    end

    summary();
    $finish;
  end

endmodule